// File: doc/BRIEF.md
# Clock Synthesizer Divider Configuration Loader

This block holds the divider settings of a clock synthesizer: a 9-bit feedback (loop) divider code, a 3-bit post divider code and a 2-bit selector for a debug pin. Two paths can write these settings into a single active register.

- **Parallel path.** It uses dedicated code pins and an active-low load strobe.
- **Serial path.** It uses a three-wire port: a data line, a shift clock and a load strobe.

The active codes drive the divider outputs continuously. The debug selector steers a small multiplexer onto the TEST pin. The PLL, the oscillator and the analog drivers sit outside this block.

All strobes, the serial clock and the serial data line are slow, asynchronous control signals. The block samples them with a fast system clock through two-flop synchronizers and detects edges on the synchronized copies. A pin change therefore takes effect on the third rising system-clock edge after it. Every interface is a plain control pin. The block carries no streaming data, so it has no valid/ready handshake and no back-pressure.

The master reset is active high. It clears the synchronizers and the shift register asynchronously. While it is held, the active register loads the feedback code from the parallel pins on every clock and clears the post divider code and the debug selector.

Top module: `synth_cfg_load`

## Requirements
- R1: While `par_load_n` is low, `m_code`/`n_code` take the values on `par_m`/`par_n` one clock later, and the debug selector is cleared to 00.
- R2: After `par_load_n` rises, the captured parallel codes stay on `m_code`/`n_code` even when `par_m`/`par_n` change afterwards.
- R3: A serial frame is 14 bits, sent most significant first. Bits [13:12] are the debug selector, bits [11:9] are the post divider code and bits [8:0] are the feedback code.
- R4: With `par_load_n` high, a rising edge of `ser_load` copies the whole shift register into the active register.
- R5: While `ser_load` stays high, each rising edge of `ser_clk` shifts in one bit and copies the shifted value into the active register.
- R6: After `ser_load` falls, the active register holds, even while further bits are shifted in with `ser_load` low.
- R7: While `par_load_n` is low, `ser_clk` edges leave the shift register unchanged.
- R8: `test_out` depends on the selector. 00 gives low. 01 gives the synchronized serial data line. 10 gives `mdiv_fb`. 11 gives `fout_clk`. While `par_load_n` is low, `test_out` is forced low.
- R9: While `mr` is high, `m_code` equals `par_m`, `n_code` is 0 and `test_out` is low. The shift register is cleared to zero.
- R10: A change on a strobe or on the serial clock shows on the outputs at the third rising `clk` edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all control pins |
| mr | input | 1 | Master reset, active high |
| par_load_n | input | 1 | Parallel load strobe, active low (transparent when low) |
| par_m | input | 9 | Parallel feedback divider code |
| par_n | input | 3 | Parallel post divider code |
| ser_clk | input | 1 | Serial shift clock (rising edge used) |
| ser_data | input | 1 | Serial data line |
| ser_load | input | 1 | Serial load strobe |
| mdiv_fb | input | 1 | Feedback divider output, routed to TEST when selected |
| fout_clk | input | 1 | Synthesized output clock, routed to TEST when selected |
| m_code | output | 9 | Active feedback divider code |
| n_code | output | 3 | Active post divider code |
| test_out | output | 1 | Debug multiplexer output |

## Verification
On every cycle, the embedded assertions check four things:
- in parallel mode the codes follow the pins one clock later and TEST stays low;
- a serial load edge copies the shift register exactly;
- the active register holds whenever no load event is decoded;
- the shift register is frozen whenever shifting is not enabled.

Some behaviour depends on the relative timing of several slow pins, and only the bench scenarios show it:
- the bit order and field positions of a full frame;
- the three-edge synchronizer latency;
- the transparent shift-and-copy mode followed by latching on the falling strobe;
- the reset values;
- each TEST selection.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  localparam int M_W     = 9;
  localparam int N_W     = 3;
  localparam int T_W     = 2;
  localparam int FRAME_W = T_W + N_W + M_W;

  // Field order matches the serial frame: selector in the top bits,
  // feedback code in the bottom bits.
  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SDATA = 2'b01,
    TSEL_MDIV  = 2'b10,
    TSEL_FOUT  = 2'b11
  } tsel_e;

endpackage

// File: rtl/cfg_sync_bank.sv
module cfg_sync_bank #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge arst) begin
      if (arst) chain <= '0;
      else      chain <= {chain[STAGES-2:0], din[i]};
    end

    assign q[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/cfg_serial_shift.sv
module cfg_serial_shift #(
  parameter int WIDTH = 14
) (
  input  logic             clk,
  input  logic             arst,
  input  logic             shift_en,
  input  logic             sdata,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_next
);

  assign q_next = {q[WIDTH-2:0], sdata};

  always_ff @(posedge clk or posedge arst) begin
    if (arst)          q <= '0;
    else if (shift_en) q <= q_next;
  end

  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (arst)
    !shift_en |=> $stable(q)); // R7

endmodule

// File: rtl/cfg_test_mux.sv
module cfg_test_mux
  import synth_cfg_pkg::*;
(
  input  tsel_e sel,
  input  logic  force_low,
  input  logic  sdata,
  input  logic  mdiv,
  input  logic  fout,
  output logic  test_o
);

  always_comb begin
    case (sel)
      TSEL_SDATA: test_o = sdata;
      TSEL_MDIV:  test_o = mdiv;
      TSEL_FOUT:  test_o = fout;
      default:    test_o = 1'b0;
    endcase
    if (force_low) test_o = 1'b0;
  end

endmodule

// File: rtl/synth_cfg_load.sv
module synth_cfg_load
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           mr,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           mdiv_fb,
  input  logic           fout_clk,
  output logic [M_W-1:0] m_code,
  output logic [N_W-1:0] n_code,
  output logic           test_out
);

  localparam int CTRL_W = 4;

  logic [CTRL_W-1:0] ctrl_s;
  logic npl_s, sload_s, sclk_s, sdata_s;
  logic sload_prev, sclk_prev;
  logic sload_rise, sclk_rise, shift_en;
  logic [FRAME_W-1:0] shift_q, shift_next;
  cfg_t active;

  cfg_sync_bank #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .arst (mr),
    .din  ({par_load_n, ser_load, ser_clk, ser_data}),
    .q    (ctrl_s)
  );

  assign {npl_s, sload_s, sclk_s, sdata_s} = ctrl_s;

  always_ff @(posedge clk or posedge mr) begin
    if (mr) begin
      sload_prev <= 1'b0;
      sclk_prev  <= 1'b0;
    end else begin
      sload_prev <= sload_s;
      sclk_prev  <= sclk_s;
    end
  end

  assign sload_rise = sload_s & ~sload_prev;
  assign sclk_rise  = sclk_s & ~sclk_prev;
  assign shift_en   = npl_s & sclk_rise;

  cfg_serial_shift #(.WIDTH(FRAME_W)) u_shift (
    .clk      (clk),
    .arst     (mr),
    .shift_en (shift_en),
    .sdata    (sdata_s),
    .q        (shift_q),
    .q_next   (shift_next)
  );

  // Active register: reset and parallel mode load from pins; serial events
  // copy the shift register; otherwise the value is held (latched).
  always_ff @(posedge clk) begin
    if (mr)
      active <= '{t: '0, n: '0, m: par_m};
    else if (!npl_s)
      active <= '{t: '0, n: par_n, m: par_m};
    else if (sload_rise)
      active <= cfg_t'(shift_q);
    else if (sload_s && sclk_rise)
      active <= cfg_t'(shift_next);
  end

  assign m_code = active.m;
  assign n_code = active.n;

  cfg_test_mux u_tmux (
    .sel       (tsel_e'(active.t)),
    .force_low (~npl_s),
    .sdata     (sdata_s),
    .mdiv      (mdiv_fb),
    .fout      (fout_clk),
    .test_o    (test_out)
  );

  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (mr)
    !npl_s |=> (m_code == $past(par_m) && n_code == $past(par_n))); // R1

  AST_PAR_TEST_LOW: assert property (@(posedge clk) disable iff (mr)
    !npl_s |-> !test_out); // R8

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (mr)
    (npl_s && sload_rise) |=> (active == $past(shift_q))); // R4

  AST_SERIAL_HOLD: assert property (@(posedge clk) disable iff (mr)
    (npl_s && !sload_rise && !(sload_s && sclk_rise)) |=> $stable(active)); // R6

endmodule

// File: tb/synth_cfg_load_test.sv
module synth_cfg_load_test;

  logic       clk = 1'b0;
  logic       mr = 1'b1;
  logic       par_load_n = 1'b1;
  logic [8:0] par_m = 9'h1A5;
  logic [2:0] par_n = 3'd3;
  logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic       mdiv_fb = 1'b0, fout_clk = 1'b0;
  logic [8:0] m_code;
  logic [2:0] n_code;
  logic       test_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  synth_cfg_load uut (
    .clk(clk), .mr(mr), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .mdiv_fb(mdiv_fb), .fout_clk(fout_clk),
    .m_code(m_code), .n_code(n_code), .test_out(test_out)
  );

  // bit14 = 1: serial frame, 0: parallel load; bits[13:0] = {t, n, m}
  localparam logic [14:0] VEC [6] = '{
    15'h04C8, 15'h6BF4, 15'h4EFA, 15'h01FF, 15'h7355, 15'h58AA
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_data = b; cyc(1);
    ser_clk = 1'b1; cyc(3);
    ser_clk = 1'b0; cyc(3);
  endtask

  task automatic send_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic pulse_load();
    ser_load = 1'b1; cyc(4);
    ser_load = 1'b0; cyc(4);
  endtask

  task automatic par_load(input logic [8:0] m, input logic [2:0] n);
    par_load_n = 1'b0; par_m = m; par_n = n; cyc(4);
    par_load_n = 1'b1; cyc(4);
  endtask

  function automatic logic exp_test(input logic [1:0] t, input logic sd,
                                    input logic md, input logic fo);
    case (t)
      2'b01:   return sd;
      2'b10:   return md;
      2'b11:   return fo;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    cyc(4);
    check("R9 m under reset", m_code, 9'h1A5);
    check("R9 n under reset", n_code, 0);
    check("R9 test under reset", test_out, 0);
    mr = 1'b0; cyc(4);
    pulse_load();
    check("R9 shift cleared m", m_code, 0);
    check("R9 shift cleared n", n_code, 0);

    // Table walk: R1, R3, R4, R8
    for (int i = 0; i < 6; i++) begin
      logic [13:0] v;
      logic [1:0]  et;
      v = VEC[i][13:0];
      if (!VEC[i][14]) begin
        par_load(v[8:0], v[11:9]);
        et = 2'b00;
      end else begin
        send_frame(v);
        pulse_load();
        et = v[13:12];
      end
      mdiv_fb = 1'b1; fout_clk = 1'b0; ser_data = 1'b0; cyc(3);
      check(VEC[i][14] ? "R3/R4 m field" : "R1 m follow", m_code, v[8:0]);
      check(VEC[i][14] ? "R3/R4 n field" : "R1 n follow", n_code, v[11:9]);
      check("R8 test select", test_out, exp_test(et, 1'b0, 1'b1, 1'b0));
      mdiv_fb = 1'b0;
    end

    // R10 latency, then R5 transparent and R6 latch
    send_frame(14'h0123);
    ser_load = 1'b1; cyc(2);
    check("R10 not before third edge", m_code, 9'h0AA);
    cyc(1);
    check("R10 on third edge", m_code, 9'h123);
    cyc(3);
    send_bit(1'b1);
    check("R5 transparent m", m_code, 9'h047);
    check("R5 transparent n", n_code, 1);
    ser_load = 1'b0; cyc(4);
    send_bit(1'b0); send_bit(1'b0);
    check("R6 latched m", m_code, 9'h047);
    check("R6 latched n", n_code, 1);

    // R2: captured parallel values ignore later pin changes
    par_load(9'h0C8, 3'd2);
    par_m = 9'h033; par_n = 3'd6; cyc(4);
    check("R2 held m", m_code, 9'h0C8);
    check("R2 held n", n_code, 2);

    // R7: shift clock ignored in parallel mode (shift holds 0x091C)
    par_load_n = 1'b0; cyc(4);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    par_load_n = 1'b1; cyc(4);
    pulse_load();
    check("R7 shift untouched m", m_code, 9'h11C);
    check("R7 shift untouched n", n_code, 4);

    // R8: each TEST source and forced low in parallel mode
    send_frame(14'h1000); pulse_load();
    ser_data = 1'b1; cyc(3);
    check("R8 sdata high", test_out, 1);
    ser_data = 1'b0; cyc(3);
    check("R8 sdata low", test_out, 0);
    send_frame(14'h3000); pulse_load();
    fout_clk = 1'b1; cyc(1);
    check("R8 fout high", test_out, 1);
    fout_clk = 1'b0; cyc(1);
    check("R8 fout low", test_out, 0);
    send_frame(14'h2000); pulse_load();
    mdiv_fb = 1'b1; cyc(1);
    check("R8 mdiv high", test_out, 1);
    par_load_n = 1'b0; cyc(4);
    check("R8 forced low in parallel", test_out, 0);
    par_load_n = 1'b1; cyc(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule